// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier Unit

This block multiplies two 16-bit integer operands and returns a 32-bit product. A 3-bit mode code says how each operand is read: as signed or unsigned, as a 5-bit unsigned literal taken from the low bits of the second operand, or as a pair of unsigned bytes. All seven readings feed one signed 17x17 array. Each operand is widened to 17 bits before the multiply: sign extension when it is signed, zero extension otherwise. Arithmetic is two's complement, and the result is the low 32 bits of the array output.

Both sides of the block are valid/ready streams. An input beat is taken on a rising edge where `in_valid` and `in_ready` are both high. Its product appears in a one-entry output register on the next cycle. The output beat leaves on an edge where `out_valid` and `out_ready` are both high. While the output is stalled (`out_valid` high, `out_ready` low), the product and `out_valid` hold, and `in_ready` stays low so that no new beat is taken. When `out_ready` is high, the unit takes one beat per cycle with no bubble. A source that sees `in_ready` low keeps its beat unchanged. The sink may lower `out_ready` at any time.

Top module: `mixed_mult_unit`

## Requirements
- R1: Mode 0 returns the product of op_a and op_b, both read as signed two's complement, truncated to 32 bits (0x8000 times 0x8000 gives 0x40000000).
- R2: Mode 1 returns the product of op_a and op_b, both read as unsigned (0xFFFF times 0xFFFF gives 0xFFFE0001).
- R3: Mode 2 reads op_a as unsigned and op_b as signed, and returns the low 32 bits of their product.
- R4: Mode 3 reads op_a as signed and op_b as unsigned, and returns the low 32 bits of their product.
- R5: Mode 4 (op_a signed) and mode 5 (op_a unsigned) multiply op_a by the unsigned literal in op_b[4:0]. Bits op_b[15:5] have no effect on the product.
- R6: Mode 6 multiplies op_a[7:0] by op_b[7:0], both unsigned. The upper bytes of both operands have no effect, and product[31:16] is zero.
- R7: Mode 7 gives the same result as mode 1.
- R8: A beat accepted on one edge sets out_valid on that edge and presents its product. When nothing new is accepted, out_valid drops after the output beat leaves.
- R9: While out_valid is high and out_ready is low, product and out_valid hold their values and in_ready is low.
- R10: After synchronous reset, out_valid is 0 and in_ready is 1.
- R11: With out_ready held high, in_ready stays high and the unit accepts and delivers one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; the literal sits in bits [4:0] |
| mode | input | 3 | Multiply mode code, 0 to 7 |
| out_valid | output | 1 | Product register holds a result |
| out_ready | input | 1 | Sink takes the result |
| product | output | 32 | Product of the beat |

## Verification
Two handshakes can fall on the same edge: the stored product leaves on the output side while a new beat enters on the input side. This is the path that carries back-to-back throughput. A long random phase drives `in_valid` and `out_ready` independently, so stalls, drains and simultaneous hand-offs are all mixed together. On every cycle the bench compares `in_ready`, `out_valid` and the presented product against a queue-based model. A simultaneous hand-off passes only if the leaving product matches the head of the queue and the entering beat's product shows up on the next cycle.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [2:0] {
    MD_SS    = 3'd0,
    MD_UU    = 3'd1,
    MD_AU_BS = 3'd2,
    MD_AS_BU = 3'd3,
    MD_SLIT  = 3'd4,
    MD_ULIT  = 3'd5,
    MD_BYTE  = 3'd6,
    MD_SPARE = 3'd7
  } mul_mode_e;

  // signedness of the first operand per mode
  function automatic logic first_is_signed(mul_mode_e m);
    return (m == MD_SS) || (m == MD_AS_BU) || (m == MD_SLIT);
  endfunction

  // signedness of the second operand per mode
  function automatic logic second_is_signed(mul_mode_e m);
    return (m == MD_SS) || (m == MD_AU_BS);
  endfunction

endpackage

// File: rtl/mmu_operand_ext.sv
module mmu_operand_ext
  import mmu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int LIT_W     = 5,
  parameter int BYTE_W    = 8,
  parameter bit SECOND_OP = 1'b0
) (
  input  logic [DATA_W-1:0] raw,
  input  mul_mode_e         mode,
  output logic [DATA_W:0]   ext
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] byte_ext;
  logic [EXT_W-1:0] full_ext;
  logic             is_signed;

  assign byte_ext = {{(EXT_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};

  generate
    if (SECOND_OP) begin : g_second
      logic [EXT_W-1:0] lit_ext;
      assign is_signed = second_is_signed(mode);
      assign lit_ext   = {{(EXT_W-LIT_W){1'b0}}, raw[LIT_W-1:0]};
      always_comb begin
        full_ext = {is_signed & raw[DATA_W-1], raw};
        case (mode)
          MD_SLIT, MD_ULIT: ext = lit_ext;
          MD_BYTE:          ext = byte_ext;
          default:          ext = full_ext;
        endcase
      end
    end else begin : g_first
      assign is_signed = first_is_signed(mode);
      always_comb begin
        full_ext = {is_signed & raw[DATA_W-1], raw};
        ext = (mode == MD_BYTE) ? byte_ext : full_ext;
      end
    end
  endgenerate

endmodule

// File: rtl/mmu_array.sv
module mmu_array #(
  parameter int IN_W  = 17,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  a,
  input  logic [IN_W-1:0]  b,
  output logic [OUT_W-1:0] p
);
  logic signed [IN_W-1:0]  sa;
  logic signed [IN_W-1:0]  sb;
  logic signed [OUT_W-1:0] sp;

  assign sa = $signed(a);
  assign sb = $signed(b);
  // low OUT_W bits of the signed product; both factors widen with sign
  assign sp = OUT_W'(sa * sb);
  assign p  = $unsigned(sp);

endmodule

// File: rtl/mmu_out_stage.sv
module mmu_out_stage #(
  parameter int PROD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [PROD_W-1:0] next_prod,
  input  logic              sink_rdy,
  output logic              full,
  output logic [PROD_W-1:0] held_prod
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b1;
    end else if (sink_rdy) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) held_prod <= next_prod;
  end

endmodule

// File: rtl/mixed_mult_unit.sv
module mixed_mult_unit
  import mmu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [2:0]          mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*DATA_W-1:0] product
);
  localparam int EXT_W  = DATA_W + 1;
  localparam int PROD_W = 2 * DATA_W;

  mul_mode_e        md;
  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [PROD_W-1:0] raw_prod;
  logic             take;

  assign md       = mul_mode_e'(mode);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  mmu_operand_ext #(
    .DATA_W(DATA_W), .LIT_W(LIT_W), .BYTE_W(BYTE_W), .SECOND_OP(1'b0)
  ) u_ext_a (
    .raw(op_a), .mode(md), .ext(ext_a)
  );

  mmu_operand_ext #(
    .DATA_W(DATA_W), .LIT_W(LIT_W), .BYTE_W(BYTE_W), .SECOND_OP(1'b1)
  ) u_ext_b (
    .raw(op_b), .mode(md), .ext(ext_b)
  );

  mmu_array #(
    .IN_W(EXT_W), .OUT_W(PROD_W)
  ) u_array (
    .a(ext_a), .b(ext_b), .p(raw_prod)
  );

  mmu_out_stage #(
    .PROD_W(PROD_W)
  ) u_out (
    .clk(clk), .rst(rst), .take(take), .next_prod(raw_prod),
    .sink_rdy(out_ready), .full(out_valid), .held_prod(product)
  );

endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [DATA_W-1:0]   op_a,
  input logic [DATA_W-1:0]   op_b,
  input logic [2:0]          mode,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*DATA_W-1:0] product
);
  localparam int PROD_W = 2 * DATA_W;

  a_r8_accept_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r8_drain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));

  a_r2_unsigned: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 3'd1) |=>
      product == ({{DATA_W{1'b0}}, $past(op_a)} * {{DATA_W{1'b0}}, $past(op_b)}));

  a_r5_ulit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 3'd5) |=>
      product == ({{DATA_W{1'b0}}, $past(op_a)} *
                  {{(PROD_W-LIT_W){1'b0}}, $past(op_b[LIT_W-1:0])}));

  a_r6_byte_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 3'd6) |=> product[PROD_W-1:DATA_W] == '0);

endmodule

bind mixed_mult_unit mmu_checker #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .mode(mode), .out_valid(out_valid),
  .out_ready(out_ready), .product(product)
);

// File: tb/test_mixed_mult_unit.sv
module test_mixed_mult_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [2:0]  mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] product;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mixed_mult_unit i_mixed_mult_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .mode(mode), .out_valid(out_valid),
    .out_ready(out_ready), .product(product)
  );

  function automatic logic [31:0] ref_prod(logic [2:0] m, logic [15:0] a, logic [15:0] b);
    longint ua, ub, sa, sb, r;
    ua = longint'(a);
    ub = longint'(b);
    sa = a[15] ? ua - 65536 : ua;
    sb = b[15] ? ub - 65536 : ub;
    case (m)
      3'd0: r = sa * sb;
      3'd1: r = ua * ub;
      3'd2: r = ua * sb;
      3'd3: r = sa * ub;
      3'd4: r = sa * (ub % 32);
      3'd5: r = ua * (ub % 32);
      3'd6: r = (ua % 256) * (ub % 256);
      default: r = ua * ub;
    endcase
    return r[31:0];
  endfunction

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // one cycle: drive at the falling edge, then judge both handshakes
  task automatic step(bit iv, logic [2:0] m, logic [15:0] a, logic [15:0] b, bit ordy);
    bit exp_ready;
    @(negedge clk);
    in_valid  = iv;
    mode      = m;
    op_a      = a;
    op_b      = b;
    out_ready = ordy;
    #1;
    check(out_valid == (exp_q.size() != 0), "R8", {31'b0, out_valid},
          {31'b0, exp_q.size() != 0});
    exp_ready = (exp_q.size() == 0) || ordy;
    check(in_ready == exp_ready, ordy ? "R11" : "R9", {31'b0, in_ready}, {31'b0, exp_ready});
    if (out_valid && exp_q.size() != 0) begin
      check(product == exp_q[0], ordy ? tag_q[0] : "R9", product, exp_q[0]);
      if (ordy) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    if (iv && in_ready) begin
      exp_q.push_back(ref_prod(m, a, b));
      tag_q.push_back(mode_tag(m));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit          hold_v;
    logic [2:0]  hm;
    logic [15:0] ha, hb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    check(out_valid == 1'b0, "R10", {31'b0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R10", {31'b0, in_ready}, 32'd1);

    // directed extremes, back to back (R11)
    step(1, 3'd0, 16'h8000, 16'h8000, 1);   // R1
    step(1, 3'd0, 16'h7FFF, 16'h8000, 1);   // R1
    step(1, 3'd0, 16'hFFFF, 16'h7FFF, 1);   // R1
    step(1, 3'd1, 16'hFFFF, 16'hFFFF, 1);   // R2
    step(1, 3'd1, 16'h8000, 16'h7FFF, 1);   // R2
    step(1, 3'd2, 16'hFFFF, 16'h8000, 1);   // R3
    step(1, 3'd2, 16'h7FFF, 16'hFFFF, 1);   // R3
    step(1, 3'd3, 16'h8000, 16'hFFFF, 1);   // R4
    step(1, 3'd3, 16'hFFFF, 16'h7FFF, 1);   // R4
    step(1, 3'd4, 16'h8000, 16'hFFFF, 1);   // R5 signed, high bits ignored
    step(1, 3'd4, 16'h7FFF, 16'hFFE0, 1);   // R5 literal zero
    step(1, 3'd5, 16'hFFFF, 16'hAB1F, 1);   // R5 unsigned
    step(1, 3'd6, 16'hFFFF, 16'hFFFF, 1);   // R6 upper bytes ignored
    step(1, 3'd6, 16'h12FF, 16'h3480, 1);   // R6
    step(1, 3'd7, 16'hFFFF, 16'h8000, 1);   // R7
    step(1, 3'd7, 16'h0000, 16'hFFFF, 1);   // R7
    // R9: stall with a waiting beat that must not enter
    step(1, 3'd0, 16'h1234, 16'h8765, 0);
    step(1, 3'd1, 16'hAAAA, 16'h5555, 0);
    step(1, 3'd1, 16'hAAAA, 16'h5555, 0);
    step(1, 3'd1, 16'hAAAA, 16'h5555, 1);
    step(0, 3'd0, 16'h0, 16'h0, 1);
    step(0, 3'd0, 16'h0, 16'h0, 1);         // R8 drained

    // random phase with independent valid and ready
    hold_v = 1'b0;
    hm = '0; ha = '0; hb = '0;
    for (int i = 0; i < 3000; i++) begin
      bit iv, rdy;
      if (!hold_v) begin
        hm = 3'($urandom_range(0, 7));
        case ($urandom_range(0, 5))
          0: ha = 16'h8000;
          1: ha = 16'h7FFF;
          2: ha = 16'hFFFF;
          default: ha = 16'($urandom);
        endcase
        case ($urandom_range(0, 5))
          0: hb = 16'h8000;
          1: hb = 16'h7FFF;
          2: hb = 16'hFFFF;
          default: hb = 16'($urandom);
        endcase
        iv = ($urandom_range(0, 3) != 0);
      end else begin
        iv = 1'b1;
      end
      rdy = ($urandom_range(0, 2) != 0);
      step(iv, hm, ha, hb, rdy);
      hold_v = iv && !in_ready;
    end
    repeat (3) step(0, 3'd0, 16'h0, 16'h0, 1);
    check(exp_q.size() == 0, "R8", 32'(exp_q.size()), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule